// File: doc/BRIEF.md
# Automatic entropy request sequencer

This block drives the command side of a random-generator application port without software help. It has three ways to start work. The first is a boot mode: once enabled, it sends a fixed instantiate word and then a fixed generate word. The second is an auto mode: it replays a preloaded generate command each time the previous command has been acknowledged. The third lets a single-word software command through, but only when auto mode is off.

In auto mode a down-counter limits how many generates may go out between reseeds. When the counter is exhausted, the preloaded reseed command goes out in place of the next generate. The counter is reloaded whenever a reseed is acknowledged. The queued commands are read word by word from two external first-word-fall-through queues through pop strobes. The bus registers and the queues themselves sit outside this block.

Every acknowledge returns a one-bit status, which is latched. A one-cycle done pulse follows each acknowledge. A busy flag covers the boot and auto activity. The control state machine uses sparse codes, and any illegal code raises a sticky fatal flag.

Top module: `entropy_req_seq`

## Requirements
- R1: After reset, cmd_vld_o, busy_o, done_o, cmd_sts_o, boot_ack_o and fatal_err_o are all 0.
- R2: With enable_i and boot_mode_i high in idle, the block sends the single word BOOT_INS_CMD (default 0x0000_0001). After that command's acknowledge it sends the single word BOOT_GEN_CMD (default 0x00FF_F003). If auto mode is off, the block then holds with busy_o low until boot mode or enable is cleared.
- R3: boot_ack_o becomes 1 on the acknowledge of the boot instantiate command. It stays 1 until enable_i is low.
- R4: In auto mode no new command word is presented between the last word of a command and its acknowledge. The next command starts in the cycle after the acknowledge.
- R5: When auto mode is entered, the counter loads from max_reqs_i. Each generate command uses one count. With a count of zero, the reseed command is sent instead. A reseed acknowledge reloads the counter, so max_reqs_i = N gives N generates between reseeds, and N = 0 gives only reseeds.
- R6: A queued command has bits [7:4] of its first word plus one words. Each word stays on cmd_word_o with cmd_vld_o high until cmd_rdy_i, and each accepted word pulses the pop strobe of its own queue once.
- R7: busy_o is high while a boot or auto command is being sent or awaits its acknowledge. It is low in idle, while boot mode is holding, and during a software command.
- R8: A software command is taken only in idle with auto mode off. It is always one word, whatever its bits [7:4]. If sw_cmd_vld_i and auto mode are both high, auto mode wins and the software word is dropped.
- R9: Every acknowledge latches ack_sts_i into cmd_sts_o (0 means success, 1 means error). done_o pulses for one cycle, in the cycle after the acknowledge.
- R10: Clearing auto_mode_i lets the command in flight finish. After its acknowledge the block returns to idle and starts no new command.
- R11: The state register uses sparse codes. An illegal code sets fatal_err_o, which stays set until reset. In normal use fatal_err_o stays 0.
- R12: With boot and auto mode both set, the boot pair goes out first and auto operation follows the boot generate acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| boot_mode_i | input | 1 | Boot-time request mode |
| auto_mode_i | input | 1 | Automatic replay mode |
| max_reqs_i | input | CNT_W | Generates allowed between reseeds |
| rsd_word_i | input | WORD_W | Head word of the reseed queue |
| rsd_pop_o | output | 1 | Pop strobe for the reseed queue |
| gen_word_i | input | WORD_W | Head word of the generate queue |
| gen_pop_o | output | 1 | Pop strobe for the generate queue |
| sw_cmd_vld_i | input | 1 | Software command offered |
| sw_cmd_word_i | input | WORD_W | Software command word |
| cmd_vld_o | output | 1 | Command word valid toward the port |
| cmd_word_o | output | WORD_W | Command word |
| cmd_rdy_i | input | 1 | Port accepts the current word |
| ack_i | input | 1 | Command acknowledge from the port |
| ack_sts_i | input | 1 | Status carried with the acknowledge |
| busy_o | output | 1 | Boot or auto command activity |
| done_o | output | 1 | One-cycle pulse after each acknowledge |
| cmd_sts_o | output | 1 | Latched acknowledge status |
| boot_ack_o | output | 1 | Boot instantiate acknowledged |
| fatal_err_o | output | 1 | Sticky illegal-state flag |

## Verification
Two events can land in the same cycle. The first pair is a software command offer and the switch into auto mode. The bench raises sw_cmd_vld_i and auto_mode_i on the same edge while the block is idle, with a zero reseed budget. It then judges that the three-word reseed command goes out and the software word never appears. The second pair is an acknowledge arriving just as auto mode is withdrawn: the bench clears auto_mode_i before the pending acknowledge and expects cmd_vld_o and busy_o to stay low afterwards.

// File: rtl/entropy_req_seq.sv
`timescale 1ns/1ps
module entropy_req_seq #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned LEN_LSB = 4,
  parameter int unsigned LEN_W   = 4,
  parameter logic [WORD_W-1:0] BOOT_INS_CMD = 32'h0000_0001,
  parameter logic [WORD_W-1:0] BOOT_GEN_CMD = 32'h00FF_F003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              boot_mode_i,
  input  logic              auto_mode_i,
  input  logic [CNT_W-1:0]  max_reqs_i,
  input  logic [WORD_W-1:0] rsd_word_i,
  output logic              rsd_pop_o,
  input  logic [WORD_W-1:0] gen_word_i,
  output logic              gen_pop_o,
  input  logic              sw_cmd_vld_i,
  input  logic [WORD_W-1:0] sw_cmd_word_i,
  output logic              cmd_vld_o,
  output logic [WORD_W-1:0] cmd_word_o,
  input  logic              cmd_rdy_i,
  input  logic              ack_i,
  input  logic              ack_sts_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cmd_sts_o,
  output logic              boot_ack_o,
  output logic              fatal_err_o
);
  localparam logic [5:0] S_IDLE = 6'b001011;
  localparam logic [5:0] S_SEND = 6'b110001;
  localparam logic [5:0] S_WAIT = 6'b010110;
  localparam logic [5:0] S_HOLD = 6'b101100;
  localparam logic [5:0] S_ERR  = 6'b111111;

  localparam logic [2:0] SRC_BI  = 3'd0;
  localparam logic [2:0] SRC_BG  = 3'd1;
  localparam logic [2:0] SRC_RSD = 3'd2;
  localparam logic [2:0] SRC_GEN = 3'd3;
  localparam logic [2:0] SRC_SW  = 3'd4;

  logic [5:0]        state_q, state_d;
  logic [2:0]        src_q, src_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  left_q;
  logic              first_q;
  logic [WORD_W-1:0] sw_word_q;
  logic              done_q, sts_q, boot_ack_q, fatal_q;

  wire auto_on  = enable_i & auto_mode_i;
  wire boot_on  = enable_i & boot_mode_i;
  wire hs       = (state_q == S_SEND) & cmd_rdy_i;
  wire ack_hit  = (state_q == S_WAIT) & ack_i;
  wire multi    = (src_q == SRC_RSD) | (src_q == SRC_GEN);
  wire [LEN_W-1:0] len_first = cmd_word_o[LEN_LSB +: LEN_W];
  wire last_word = first_q ? (!multi || len_first == '0) : (left_q == LEN_W'(1));

  wire [CNT_W-1:0] base     = (ack_hit && src_q == SRC_GEN) ? cnt_q : max_reqs_i;
  wire [2:0]       pick_src = (base == '0) ? SRC_RSD : SRC_GEN;
  wire [CNT_W-1:0] pick_cnt = (base == '0) ? base : base - CNT_W'(1);

  always_comb begin
    case (src_q)
      SRC_BI:  cmd_word_o = BOOT_INS_CMD;
      SRC_BG:  cmd_word_o = BOOT_GEN_CMD;
      SRC_RSD: cmd_word_o = rsd_word_i;
      SRC_GEN: cmd_word_o = gen_word_i;
      default: cmd_word_o = sw_word_q;
    endcase
  end

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    cnt_d   = cnt_q;
    case (state_q)
      S_IDLE: begin
        if (boot_on) begin
          src_d = SRC_BI; state_d = S_SEND;
        end else if (auto_on) begin
          src_d = pick_src; cnt_d = pick_cnt; state_d = S_SEND;
        end else if (enable_i && sw_cmd_vld_i) begin
          src_d = SRC_SW; state_d = S_SEND;
        end
      end
      S_SEND: if (hs && last_word) state_d = S_WAIT;
      S_WAIT: if (ack_i) begin
        case (src_q)
          SRC_BI: begin
            if (enable_i) begin src_d = SRC_BG; state_d = S_SEND; end
            else state_d = S_IDLE;
          end
          SRC_BG, SRC_RSD, SRC_GEN: begin
            if (src_q == SRC_RSD) cnt_d = max_reqs_i;
            if (auto_on) begin
              src_d = pick_src; cnt_d = pick_cnt; state_d = S_SEND;
            end else begin
              state_d = (src_q == SRC_BG && boot_on) ? S_HOLD : S_IDLE;
            end
          end
          SRC_SW:  state_d = S_IDLE;
          default: state_d = S_ERR;
        endcase
      end
      S_HOLD: begin
        if (auto_on) begin
          src_d = pick_src; cnt_d = pick_cnt; state_d = S_SEND;
        end else if (!boot_on) state_d = S_IDLE;
      end
      S_ERR:   state_d = S_ERR;
      default: state_d = S_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      src_q      <= SRC_SW;
      cnt_q      <= '0;
      left_q     <= '0;
      first_q    <= 1'b1;
      sw_word_q  <= '0;
      done_q     <= 1'b0;
      sts_q      <= 1'b0;
      boot_ack_q <= 1'b0;
      fatal_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      cnt_q   <= cnt_d;
      if (state_q == S_IDLE && state_d == S_SEND && src_d == SRC_SW) sw_word_q <= sw_cmd_word_i;
      if (state_d == S_SEND && state_q != S_SEND) first_q <= 1'b1;
      else if (hs) first_q <= 1'b0;
      if (hs) left_q <= first_q ? len_first : left_q - LEN_W'(1);
      done_q <= ack_hit;
      if (ack_i) sts_q <= ack_sts_i;
      if (!enable_i) boot_ack_q <= 1'b0;
      else if (ack_hit && src_q == SRC_BI) boot_ack_q <= 1'b1;
      if (state_d == S_ERR) fatal_q <= 1'b1;
    end
  end

  assign cmd_vld_o   = (state_q == S_SEND);
  assign rsd_pop_o   = hs & (src_q == SRC_RSD);
  assign gen_pop_o   = hs & (src_q == SRC_GEN);
  assign busy_o      = ((state_q == S_SEND) | (state_q == S_WAIT)) & (src_q != SRC_SW);
  assign done_o      = done_q;
  assign cmd_sts_o   = sts_q;
  assign boot_ack_o  = boot_ack_q;
  assign fatal_err_o = fatal_q;
endmodule

// File: rtl/entropy_req_seq_chk.sv
`timescale 1ns/1ps
module entropy_req_seq_chk #(
  parameter logic [2:0] SW_CODE = 3'd4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_vld_o,
  input logic       cmd_rdy_i,
  input logic       ack_i,
  input logic       ack_sts_i,
  input logic       auto_mode_i,
  input logic       done_o,
  input logic       cmd_sts_o,
  input logic       fatal_err_o,
  input logic       busy_o,
  input logic [2:0] src_q
);
  a_r6_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && !cmd_rdy_i |=> cmd_vld_o);

  a_r9_done_follows_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ack_i));

  a_r9_sts_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> cmd_sts_o == $past(ack_sts_i));

  a_r11_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_err_o |=> fatal_err_o);

  a_r8_sw_not_in_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_vld_o) && src_q == SW_CODE |-> !$past(auto_mode_i));

  a_r7_sw_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && src_q == SW_CODE |-> !busy_o);
endmodule

bind entropy_req_seq entropy_req_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_o(cmd_vld_o), .cmd_rdy_i(cmd_rdy_i),
  .ack_i(ack_i), .ack_sts_i(ack_sts_i), .auto_mode_i(auto_mode_i), .done_o(done_o),
  .cmd_sts_o(cmd_sts_o), .fatal_err_o(fatal_err_o), .busy_o(busy_o), .src_q(src_q)
);

// File: tb/entropy_req_seq_tb.sv
`timescale 1ns/1ps
module entropy_req_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, boot_mode = 0, auto_mode = 0;
  logic [31:0] max_reqs = 0;
  logic sw_vld = 0; logic [31:0] sw_word = 0;
  logic cmd_rdy = 1, ack = 0, ack_sts = 0;
  logic rsd_pop, gen_pop, cmd_vld, busy, done, cmd_sts, boot_ack, fatal;
  logic [31:0] cmd_word;
  logic [31:0] rsd_mem [0:2];
  logic [31:0] gen_mem [0:1];
  int rsd_idx = 0, gen_idx = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] got [0:15];
  int got_n;

  always #2.5 clk = ~clk;

  entropy_req_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .boot_mode_i(boot_mode),
    .auto_mode_i(auto_mode), .max_reqs_i(max_reqs),
    .rsd_word_i(rsd_mem[rsd_idx]), .rsd_pop_o(rsd_pop),
    .gen_word_i(gen_mem[gen_idx]), .gen_pop_o(gen_pop),
    .sw_cmd_vld_i(sw_vld), .sw_cmd_word_i(sw_word),
    .cmd_vld_o(cmd_vld), .cmd_word_o(cmd_word), .cmd_rdy_i(cmd_rdy),
    .ack_i(ack), .ack_sts_i(ack_sts), .busy_o(busy), .done_o(done),
    .cmd_sts_o(cmd_sts), .boot_ack_o(boot_ack), .fatal_err_o(fatal));

  always @(posedge clk) begin
    if (rsd_pop) rsd_idx <= (rsd_idx == 2) ? 0 : rsd_idx + 1;
    if (gen_pop) gen_idx <= (gen_idx == 1) ? 0 : gen_idx + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic grab();
    int t = 0;
    got_n = 0;
    while (!cmd_vld && t < 50) begin @(negedge clk); t++; end
    while (cmd_vld && got_n < 16) begin
      got[got_n] = cmd_word; got_n++;
      @(negedge clk);
    end
  endtask

  task automatic give_ack(input logic s, input string tag);
    ack = 1; ack_sts = s;
    @(negedge clk);
    ack = 0; ack_sts = 0;
    chk({tag, " R9 done pulse"}, done, 1);
    chk({tag, " R9 status latched"}, cmd_sts, s);
  endtask

  task automatic expect_gen(input string tag);
    grab();
    chk({tag, " R6 gen length"}, got_n, 2);
    chk({tag, " R6 gen word0"}, got[0], 32'h0000_0013);
    chk({tag, " R6 gen word1"}, got[1], 32'hA5A5_0001);
  endtask

  task automatic expect_rsd(input string tag);
    grab();
    chk({tag, " R5 reseed length"}, got_n, 3);
    chk({tag, " R5 reseed word0"}, got[0], 32'h0000_0021);
    chk({tag, " R5 reseed word2"}, got[2], 32'h0000_0022);
  endtask

  task automatic t_reset();
    chk("R1 cmd_vld", cmd_vld, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 cmd_sts", cmd_sts, 0);
    chk("R1 boot_ack", boot_ack, 0);
    chk("R1 fatal", fatal, 0);
  endtask

  task automatic t_boot();
    enable = 1; boot_mode = 1;
    @(negedge clk);
    chk("R7 busy in boot", busy, 1);
    grab();
    chk("R2 ins length", got_n, 1);
    chk("R2 ins word", got[0], 32'h0000_0001);
    repeat (3) @(negedge clk);
    chk("R4 no word before ack", cmd_vld, 0);
    give_ack(0, "boot ins");
    chk("R3 boot_ack set", boot_ack, 1);
    grab();
    chk("R2 gen length", got_n, 1);
    chk("R2 gen word", got[0], 32'h00FF_F003);
    give_ack(1, "boot gen");
    repeat (3) @(negedge clk);
    chk("R2 hold no cmd", cmd_vld, 0);
    chk("R7 hold not busy", busy, 0);
    chk("R3 boot_ack held", boot_ack, 1);
    boot_mode = 0; enable = 0;
    @(negedge clk);
    chk("R3 boot_ack cleared", boot_ack, 0);
    @(negedge clk);
  endtask

  task automatic t_auto();
    max_reqs = 2; cmd_rdy = 0;
    enable = 1; auto_mode = 1;
    repeat (3) @(negedge clk);
    chk("R6 held valid", cmd_vld, 1);
    chk("R6 held word", cmd_word, 32'h0000_0013);
    cmd_rdy = 1;
    expect_gen("auto 1");
    repeat (2) @(negedge clk);
    chk("R4 wait for ack", cmd_vld, 0);
    chk("R7 busy waiting", busy, 1);
    give_ack(0, "auto 1");
    expect_gen("auto 2");
    give_ack(0, "auto 2");
    expect_rsd("auto 3");
    give_ack(1, "auto 3");
    expect_gen("auto 4 R5 reload");
    give_ack(0, "auto 4");
    expect_gen("auto 5");
    give_ack(0, "auto 5");
    expect_rsd("auto 6");
    give_ack(0, "auto 6");
    expect_gen("auto 7");
    auto_mode = 0;
    give_ack(0, "auto 7 R10");
    repeat (4) @(negedge clk);
    chk("R10 idle after stop", cmd_vld, 0);
    chk("R10 not busy", busy, 0);
    enable = 0;
    @(negedge clk);
  endtask

  task automatic t_sw_race();
    max_reqs = 0; enable = 1;
    auto_mode = 1; sw_vld = 1; sw_word = 32'hDEAD_BEE1;
    @(negedge clk);
    sw_vld = 0;
    expect_rsd("R8 auto wins");
    chk("R8 sw word dropped", got[0] == 32'hDEAD_BEE1, 0);
    give_ack(0, "R5 zero budget 1");
    expect_rsd("R5 zero budget 2");
    auto_mode = 0;
    give_ack(0, "R10 zero budget");
    repeat (3) @(negedge clk);
    chk("R8 no late sw", cmd_vld, 0);
    sw_vld = 1; sw_word = 32'h1234_56F1;
    @(negedge clk);
    sw_vld = 0;
    chk("R7 sw not busy", busy, 0);
    grab();
    chk("R8 sw single word", got_n, 1);
    chk("R8 sw word", got[0], 32'h1234_56F1);
    give_ack(1, "sw");
    enable = 0;
    @(negedge clk);
  endtask

  task automatic t_boot_auto();
    max_reqs = 1; enable = 1; boot_mode = 1; auto_mode = 1;
    grab();
    chk("R12 boot ins first", got[0], 32'h0000_0001);
    give_ack(0, "R12 ins");
    grab();
    chk("R12 boot gen second", got[0], 32'h00FF_F003);
    give_ack(0, "R12 gen");
    expect_gen("R12 auto gen");
    give_ack(0, "R12 auto gen");
    expect_rsd("R12 auto rsd");
    auto_mode = 0; boot_mode = 0;
    give_ack(0, "R12 rsd");
    repeat (3) @(negedge clk);
    chk("R12 idle", cmd_vld, 0);
    chk("R11 no fatal", fatal, 0);
    enable = 0;
  endtask

  initial begin
    rsd_mem[0] = 32'h0000_0021; rsd_mem[1] = 32'h0000_0011; rsd_mem[2] = 32'h0000_0022;
    gen_mem[0] = 32'h0000_0013; gen_mem[1] = 32'hA5A5_0001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_boot();
    t_auto();
    t_sw_race();
    t_boot_auto();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule